// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window between a host processor and an embedded system controller. The host fills a payload staging area of up to four 32-bit words and then writes a 32-bit command word. That write is the commit point. The command word and the whole staging area are copied into a held image for the controller, the block reports busy, and it sends the controller a one-cycle doorbell. While busy is set, the controller reads the held command and payload from dedicated output ports. Those values do not change until the controller completes the command.

When the controller finishes, it pulses its completion input and presents several values at once: an error flag, an 8-bit error code, an 8-bit initiator id and up to four response words. In that same clock edge the block clears busy, updates the status fields and loads the response buffer. The host has two ways to learn of completion. It can poll the status register, or it can set the completion-interrupt bit in the command word and receive a one-cycle interrupt pulse, which needs no clear. A command write that arrives while busy is set is dropped, and a sticky overrun flag records that it happened.

The host port is a simple synchronous register interface. Read data is registered and appears one cycle after the read strobe. A byte-read qualifier selects one byte of the addressed word. Decoding uses the word address, so any byte offset inside a register or buffer word reaches that word. All state resets synchronously on an active-high reset.

Top module: `hc_mailbox`

## Requirements
- R1: After reset, busy, error and overrun are 0, the status register reads 0, the read buffer holds zeros, and h_rdata, h_irq and c_doorbell are all 0.
- R2: The host writes the command register at offset 0x00 while busy is 0. The write is accepted: c_cmd takes the written word, c_doorbell is high for exactly the one cycle after the write, and busy (status bit 0) becomes 1. The same write clears the error flag (bit 1), the error code (bits 23:16) and the overrun flag (bit 2), and loads command bits 15:12 into status bits 7:4.
- R3: The payload staging words are written at offsets 0x80, 0x84, 0x88 and 0x8C, and word n occupies c_payload bits 32n+31:32n. An accepted command copies all staging words to c_payload. While busy is set, c_cmd and c_payload hold steady, including when the host writes the staging words.
- R4: A command write that arrives while busy is 1 leaves c_cmd unchanged and raises no doorbell. It sets the overrun flag (status bit 2), which stays set until the next accepted command. This also applies when the write lands in the same cycle as a completion.
- R5: A c_done pulse while busy is set clears busy in the same clock edge that loads the status fields. The error flag (bit 1) takes c_err, bits 23:16 take c_err_code and bits 15:8 take c_init_id. Read-buffer word n takes c_resp bits 32n+31:32n. Status bits 31:24 and bit 3 read 0.
- R6: A c_done pulse while busy is 0 has no effect: status and read buffer are unchanged and h_irq stays 0.
- R7: h_irq is high for exactly the one cycle after an accepted completion, and only when bit 8 of the held command word is 1.
- R8: The read buffer is at offsets 0x90 to 0x9F. A word read returns the stored response word. A byte read (h_rd_byte=1) returns, zero-extended, byte (offset mod 4) of word (offset-0x90)/4, where byte 0 is bits 7:0.
- R9: h_rdata is updated only in the cycle after h_rd_en. Reads of the command register, the staging words and every unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_rd_byte | input | 1 | Host read returns one byte instead of a word |
| h_addr | input | 8 | Host byte offset in the register window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after the strobe |
| h_irq | output | 1 | Host completion interrupt pulse |
| c_doorbell | output | 1 | Controller doorbell pulse on accepted command |
| c_cmd | output | 32 | Held command word |
| c_payload | output | 128 | Held payload, word n at bits 32n+31:32n |
| c_done | input | 1 | Controller completion pulse |
| c_err | input | 1 | Completion error flag |
| c_err_code | input | 8 | Completion error code |
| c_init_id | input | 8 | Completion initiator id |
| c_resp | input | 128 | Response words, word n at bits 32n+31:32n |

## Verification
The bench targets four corner cases, each with a clear failure signature:

- **Staging write while busy.** The host writes the staging area while a command is pending. A design that exposed the staging area directly would show the new payload to the controller in the middle of a command.
- **Command write while busy.** A design that accepted this write would overwrite c_cmd and ring the doorbell a second time. A design that forgot the event would leave the overrun flag clear.
- **Completion and command write in the same cycle.** Busy must clear, the write must be dropped and overrun must be set. A design that checked busy after the completion would accept the write instead.
- **Stray completion while idle.** A design that did not gate completion on busy would corrupt the status and response data and raise h_irq.

Random commands with random completion-interrupt bits, error fields and response words are mixed with byte and word reads at every read-buffer offset. An inverted interrupt gate, a wrong byte lane or a stale echo of the sub-command id each show up as a read or port mismatch.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W      = 32;
  localparam int CMD_IOC_BIT = 8;
  localparam int CMD_SUB_LSB = 12;
  localparam int SUB_W       = 4;
  localparam int CODE_W      = 8;
  localparam int INIT_W      = 8;

  typedef struct packed {
    logic [7:0]        rsvd_hi;
    logic [CODE_W-1:0] code;
    logic [INIT_W-1:0] init;
    logic [SUB_W-1:0]  sub;
    logic              rsvd_lo;
    logic              ovr;
    logic              err;
    logic              busy;
  } mbx_status_t;
endpackage

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              done_in,
  input  logic              done_err,
  input  logic [CODE_W-1:0] done_code,
  input  logic [INIT_W-1:0] done_init,
  output logic              accept,
  output logic              done_ok,
  output logic              busy,
  output mbx_status_t       status,
  output logic [WORD_W-1:0] cmd_q,
  output logic              doorbell,
  output logic              irq
);
  assign accept  = cmd_wr && !status.busy;
  assign done_ok = done_in && status.busy;
  assign busy    = status.busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      status   <= '0;
      cmd_q    <= '0;
      doorbell <= 1'b0;
      irq      <= 1'b0;
    end else begin
      doorbell <= accept;
      irq      <= done_ok && cmd_q[CMD_IOC_BIT];
      if (accept) begin
        cmd_q       <= cmd_word;
        status.busy <= 1'b1;
        status.err  <= 1'b0;
        status.code <= '0;
        status.ovr  <= 1'b0;
        status.sub  <= cmd_word[CMD_SUB_LSB +: SUB_W];
      end else if (cmd_wr) begin
        status.ovr <= 1'b1;
      end
      if (done_ok) begin
        status.busy <= 1'b0;
        status.err  <= done_err;
        status.code <= done_code;
        status.init <= done_init;
      end
    end
  end

  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !status.busy) |=> (status.busy && doorbell));
  assert_doorbell_single_R2: assert property (@(posedge clk) disable iff (rst)
    doorbell |=> !doorbell);
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (status.busy && $past(status.busy)) |-> $stable(cmd_q));
  assert_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && status.busy) |=> (status.ovr && $stable(cmd_q) && !doorbell));
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (done_in && status.busy) |=> !status.busy);
  assert_idle_done_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (done_in && !status.busy && !cmd_wr) |=> ($stable(status) && !irq));
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_in && status.busy && cmd_q[CMD_IOC_BIT]));
endmodule

// File: rtl/mbx_wbuf.sv
module mbx_wbuf
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        widx,
  input  logic [WORD_W-1:0]       wdata,
  input  logic                    latch,
  input  logic                    busy,
  output logic [WORDS*WORD_W-1:0] payload
);
  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] held_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        held_q  <= '0;
      end else begin
        if (wr_en && widx == IDX_W'(i)) stage_q <= wdata;
        if (latch) held_q <= stage_q;
      end
    end
    assign payload[i*WORD_W +: WORD_W] = held_q;
  end

  assert_payload_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(payload));
endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [WORDS*WORD_W-1:0] resp,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [WORD_W-1:0]       rd_word
);
  logic [WORD_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < WORDS; i++) store[i] <= resp[i*WORD_W +: WORD_W];
    end
  end

  assign rd_word = store[rd_idx];
endmodule

// File: rtl/hc_mailbox.sv
module hc_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WORDS    = 4,
  parameter int CMD_OFS  = 'h00,
  parameter int STAT_OFS = 'h04,
  parameter int WBUF_OFS = 'h80,
  parameter int RBUF_OFS = 'h90,
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int WA_W    = ADDR_W - 2,
  localparam int BUF_W   = WORDS * WORD_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic              h_rd_byte,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  output logic              h_irq,
  output logic              c_doorbell,
  output logic [WORD_W-1:0] c_cmd,
  output logic [BUF_W-1:0]  c_payload,
  input  logic              c_done,
  input  logic              c_err,
  input  logic [CODE_W-1:0] c_err_code,
  input  logic [INIT_W-1:0] c_init_id,
  input  logic [BUF_W-1:0]  c_resp
);
  logic [WA_W-1:0]   wa;
  int unsigned       wa_i;
  logic              is_cmd, is_stat, is_wb, is_rb;
  logic [IDX_W-1:0]  idx;
  logic              accept, done_ok, busy;
  mbx_status_t       status;
  logic [WORD_W-1:0] rb_word, rd_word, shifted;

  assign wa      = h_addr[ADDR_W-1:2];
  assign wa_i    = 32'(wa);
  assign is_cmd  = wa_i == CMD_OFS / 4;
  assign is_stat = wa_i == STAT_OFS / 4;
  assign is_wb   = (wa_i >= WBUF_OFS / 4) && (wa_i < WBUF_OFS / 4 + WORDS);
  assign is_rb   = (wa_i >= RBUF_OFS / 4) && (wa_i < RBUF_OFS / 4 + WORDS);
  assign idx     = wa[IDX_W-1:0];

  mbx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_wr(h_wr_en && is_cmd), .cmd_word(h_wdata),
    .done_in(c_done), .done_err(c_err), .done_code(c_err_code), .done_init(c_init_id),
    .accept(accept), .done_ok(done_ok), .busy(busy), .status(status),
    .cmd_q(c_cmd), .doorbell(c_doorbell), .irq(h_irq)
  );

  mbx_wbuf #(.WORDS(WORDS)) u_wbuf (
    .clk(clk), .rst(rst),
    .wr_en(h_wr_en && is_wb), .widx(idx), .wdata(h_wdata),
    .latch(accept), .busy(busy), .payload(c_payload)
  );

  mbx_rbuf #(.WORDS(WORDS)) u_rbuf (
    .clk(clk), .rst(rst),
    .load(done_ok), .resp(c_resp), .rd_idx(idx), .rd_word(rb_word)
  );

  always_comb begin
    rd_word = '0;
    if (is_stat)    rd_word = status;
    else if (is_rb) rd_word = rb_word;
  end

  assign shifted = rd_word >> {h_addr[1:0], 3'b000};

  always_ff @(posedge clk) begin
    if (rst)          h_rdata <= '0;
    else if (h_rd_en) h_rdata <= h_rd_byte ? {24'b0, shifted[7:0]} : rd_word;
  end

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !h_rd_en |=> $stable(h_rdata));
  assert_wo_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (h_rd_en && (is_cmd || is_wb)) |=> (h_rdata == '0));
endmodule

// File: tb/hc_mailbox_tb_top.sv
`timescale 1ns/1ps
module hc_mailbox_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         h_wr_en = 0, h_rd_en = 0, h_rd_byte = 0;
  logic [7:0]   h_addr = 0;
  logic [31:0]  h_wdata = 0;
  logic [31:0]  h_rdata;
  logic         h_irq, c_doorbell;
  logic [31:0]  c_cmd;
  logic [127:0] c_payload;
  logic         c_done = 0, c_err = 0;
  logic [7:0]   c_err_code = 0, c_init_id = 0;
  logic [127:0] c_resp = 0;

  always #2.5 clk = ~clk;

  hc_mailbox dut_i (
    .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_rd_byte(h_rd_byte),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .c_doorbell(c_doorbell), .c_cmd(c_cmd), .c_payload(c_payload), .c_done(c_done),
    .c_err(c_err), .c_err_code(c_err_code), .c_init_id(c_init_id), .c_resp(c_resp)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model
  logic [127:0] m_stage = 0, m_held = 0, m_resp = 0;
  logic [31:0]  m_cmd = 0;
  logic         m_busy = 0, m_err = 0, m_ovr = 0;
  logic [7:0]   m_code = 0, m_init = 0;
  logic [3:0]   m_sub = 0;

  function automatic logic [31:0] exp_status();
    return {8'h00, m_code, m_init, m_sub, 1'b0, m_ovr, m_err, m_busy};
  endfunction

  function automatic logic [31:0] exp_rbuf(input int off, input bit byte_rd);
    if (byte_rd) return {24'b0, m_resp[off*8 +: 8]};
    return m_resp[(off/4)*32 +: 32];
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    h_wr_en = 1; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_wr_en = 0;
  endtask

  task automatic host_rd(input logic [7:0] a, input bit b, output logic [31:0] d);
    @(negedge clk);
    h_rd_en = 1; h_addr = a; h_rd_byte = b;
    @(negedge clk);
    h_rd_en = 0; h_rd_byte = 0;
    d = h_rdata;
  endtask

  task automatic stage_wr(input int w, input logic [31:0] d);
    host_wr(8'(8'h80 + 4*w), d);
    m_stage[w*32 +: 32] = d;
  endtask

  task automatic issue_cmd(input logic [31:0] cmd);
    host_wr(8'h00, cmd);
    if (!m_busy) begin
      m_cmd = cmd; m_held = m_stage; m_busy = 1; m_err = 0; m_code = 0;
      m_ovr = 0; m_sub = cmd[15:12];
      chk("R2 doorbell high after accept", 128'(c_doorbell), 128'd1);
    end else begin
      m_ovr = 1;
      chk("R4 no doorbell on busy write", 128'(c_doorbell), 128'd0);
    end
    chk("R2 c_cmd", 128'(c_cmd), 128'(m_cmd));
    chk("R3 payload latched", c_payload, m_held);
    @(negedge clk);
    chk("R2 doorbell one cycle", 128'(c_doorbell), 128'd0);
  endtask

  task automatic complete(input bit e, input logic [7:0] code, input logic [7:0] init,
                          input logic [127:0] resp);
    bit fire;
    @(negedge clk);
    c_done = 1; c_err = e; c_err_code = code; c_init_id = init; c_resp = resp;
    @(negedge clk);
    c_done = 0;
    fire = m_busy && m_cmd[8];
    if (m_busy) begin
      m_busy = 0; m_err = e; m_code = code; m_init = init; m_resp = resp;
      chk("R7 irq after completion", 128'(h_irq), 128'(fire));
    end else begin
      chk("R6 no irq on idle completion", 128'(h_irq), 128'd0);
    end
    @(negedge clk);
    chk("R7 irq single cycle", 128'(h_irq), 128'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 rdata reset", 128'(h_rdata), 128'd0);
    chk("R1 irq reset", 128'(h_irq), 128'd0);
    chk("R1 doorbell reset", 128'(c_doorbell), 128'd0);
    host_rd(8'h04, 0, rd); chk("R1 status reset", 128'(rd), 128'd0);
    host_rd(8'h94, 0, rd); chk("R1 rbuf reset", 128'(rd), 128'd0);

    // R9 write-only and unmapped reads
    stage_wr(0, 32'hDEADBEEF);
    host_rd(8'h80, 0, rd); chk("R9 staging reads zero", 128'(rd), 128'd0);
    host_rd(8'h00, 0, rd); chk("R9 command reads zero", 128'(rd), 128'd0);
    host_rd(8'h40, 0, rd); chk("R9 unmapped reads zero", 128'(rd), 128'd0);
    @(negedge clk);
    chk("R9 rdata holds without strobe", 128'(h_rdata), 128'd0);

    // R6 completion while idle
    complete(1, 8'h5A, 8'hA5, {4{32'h12345678}});
    host_rd(8'h04, 0, rd); chk("R6 status unchanged", 128'(rd), 128'(exp_status()));
    host_rd(8'h90, 0, rd); chk("R6 rbuf unchanged", 128'(rd), 128'd0);

    // random commands
    for (int it = 0; it < 40; it++) begin
      int nw;
      logic [127:0] resp;
      nw = $urandom_range(0, 4);
      for (int k = 0; k < nw; k++) stage_wr($urandom_range(0, 3), $urandom);
      issue_cmd($urandom);
      host_rd(8'h04, 0, rd); chk("R2 status after accept", 128'(rd), 128'(exp_status()));
      if ($urandom_range(0, 1) == 1) begin
        stage_wr($urandom_range(0, 3), $urandom);
        chk("R3 payload held during busy", c_payload, m_held);
      end
      if ($urandom_range(0, 2) == 0) begin
        issue_cmd($urandom);
        host_rd(8'h04, 0, rd); chk("R4 overrun set", 128'(rd), 128'(exp_status()));
      end
      resp = {$urandom, $urandom, $urandom, $urandom};
      complete(1'($urandom), 8'($urandom), 8'($urandom), resp);
      host_rd(8'h04, 0, rd); chk("R5 status after completion", 128'(rd), 128'(exp_status()));
      for (int k = 0; k < 2; k++) begin
        int off; bit b;
        off = $urandom_range(0, 15);
        b = 1'($urandom);
        if (!b) off = off & ~3;
        host_rd(8'(8'h90 + off), b, rd);
        chk("R8 rbuf read", 128'(rd), 128'(exp_rbuf(off, b)));
      end
    end

    // R8 every byte lane
    for (int off = 0; off < 16; off++) begin
      host_rd(8'(8'h90 + off), 1, rd);
      chk("R8 byte lane", 128'(rd), 128'(exp_rbuf(off, 1)));
    end

    // R4 and R5: completion in the same cycle as a busy command write
    issue_cmd(32'h0000_51FF);
    @(negedge clk);
    c_done = 1; c_err = 0; c_err_code = 8'h33; c_init_id = 8'h44; c_resp = {4{32'hCAFEF00D}};
    h_wr_en = 1; h_addr = 8'h00; h_wdata = 32'h0000_7077;
    @(negedge clk);
    c_done = 0; h_wr_en = 0;
    m_busy = 0; m_code = 8'h33; m_init = 8'h44; m_err = 0; m_resp = {4{32'hCAFEF00D}}; m_ovr = 1;
    chk("R4 simultaneous write dropped", 128'(c_cmd), 128'h0000_51FF);
    chk("R4 no doorbell simultaneous", 128'(c_doorbell), 128'd0);
    chk("R7 irq with ioc set", 128'(h_irq), 128'd1);
    host_rd(8'h04, 0, rd); chk("R5 status after simultaneous", 128'(rd), 128'(exp_status()));
    issue_cmd(32'h0000_A0C3);
    host_rd(8'h04, 0, rd); chk("R4 overrun cleared by accept", 128'(rd), 128'(exp_status()));
    complete(0, 8'h00, 8'h01, 128'd7);
    host_rd(8'h90, 0, rd); chk("R5 rbuf word0", 128'(rd), 128'd7);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule